// File: doc/BRIEF.md
# Configuration start-up sequencer

This controller handles the end of a configuration load and the move into user mode. A reprogram request on the active-low `prog_n_i` pin clears the stored configuration state, unless a partial-reload option was kept from the previous load. While the request is held, the user I/Os are in high impedance and global set/reset is asserted. When the pin is released, the controller samples the mode-select pins, pulses `load_start_o`, and waits for the loader to raise `cfg_done_i`.

Once the loader reports completion, three start-up events fire: the DONE pin is released, the user I/Os are enabled, and global set/reset is deasserted. Each event has its own phase, from 0 to 3, taken from the option inputs. The phase counter steps on every configuration clock, or on rising edges of a user clock that is synchronised into the configuration clock domain. In handshake mode, the events that have not yet fired wait until the external DONE sense input is seen high. DONE is open-drain: the block only enables a low driver. After the last step it reports finished and holds its outputs.

Top module: `cfg_startup`

## Requirements
- R1: A low level on `prog_n_i` held for at least 2 clocks forces the clear state from any state within 3 clock edges. In the clear state `done_oe_o`=1, `finished_o`=0, `io_en_o`=0 and `gsr_o`=1, unless option R10 says otherwise.
- R2: After `prog_n_i` returns high, `load_start_o` is high for exactly one cycle. In that cycle `mode_o` equals the value of `mode_sel_i` that was sampled when the clear state ended. `mode_o` then holds while the load runs.
- R3: `mem_clear_o` is high in the clear state unless `partial_i` was 1 when the previous load completed. In that case `mem_clear_o` stays 0.
- R4: The edge at which the block sees `cfg_done_i` high while loading is tick 0. In clock timebase every later clock edge is a tick. An event with phase p becomes active at tick p+1: `done_oe_o` goes 0, `io_en_o` goes 1, `gsr_o` goes 0.
- R5: Events that share a phase value change on the same cycle.
- R6: DONE is released only by `done_oe_o`=0, and `done_oe_o` is 0 whenever `finished_o` is 1.
- R7: `finished_o` rises at tick 4. All outputs then hold until the next reprogram request, and `cfg_done_i` has no effect.
- R8: When `use_uclk_i`=1, ticks are rising edges of `uclk_i` after a two-flop synchroniser, so the first tick may come up to one user-clock period late.
- R9: When `sync_done_i`=1 and DONE has been released, the phase counter halts while the synchronised `done_sense_i` is low. Once it is seen high, ticks resume one per timebase step.
- R10: `no_gsr_i`=1 keeps `gsr_o` at 0, and `no_tri_i`=1 keeps `io_en_o` at 1, throughout the next clear and load. Both options are latched at completion of the current load.
- R11: The phase selects, the timebase and the handshake options are latched at tick 0. Later changes on those inputs do not affect the running start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_n_i | input | 1 | Reprogram request, active low, asynchronous |
| cfg_done_i | input | 1 | Loader reports the configuration load is complete |
| done_sense_i | input | 1 | Sensed level of the external DONE pin |
| uclk_i | input | 1 | User clock, sampled as data |
| mode_sel_i | input | MODE_W | Mode-select pins |
| done_sel_i | input | PH_W | Phase of the DONE release |
| io_sel_i | input | PH_W | Phase of the I/O enable |
| gsr_sel_i | input | PH_W | Phase of the set/reset release |
| use_uclk_i | input | 1 | 1 selects the user-clock timebase |
| sync_done_i | input | 1 | 1 enables the DONE-high handshake |
| partial_i | input | 1 | 1 skips the memory clear on the next reprogram |
| no_gsr_i | input | 1 | 1 suppresses set/reset during the next load |
| no_tri_i | input | 1 | 1 keeps I/Os enabled during the next load |
| done_oe_o | output | 1 | 1 drives DONE low; 0 releases it |
| io_en_o | output | 1 | 1 means the user I/Os leave high impedance |
| gsr_o | output | 1 | Global set/reset asserted |
| mem_clear_o | output | 1 | Clear the configuration memory |
| load_start_o | output | 1 | One-cycle pulse that starts a new load |
| mode_o | output | MODE_W | Latched mode-select value |
| finished_o | output | 1 | Start-up complete |

## Verification
The bench uses the default parameters: four phases, a 3-bit mode field and two-flop synchronisers. With these values every phase placement, including shared phases, can be covered by a short table. With a user clock of ten configuration clocks, the synchronisation delay and slower stepping can be seen directly in the finish cycle. The external DONE pin is modelled as an open-drain line that the bench can hold low, which exercises the handshake stall and the exact resume cycle after release.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_SAMPLE,
    ST_LOAD,
    ST_RUN,
    ST_FIN
  } su_state_t;

  localparam int unsigned NUM_EVENTS = 3;
  localparam int unsigned EV_DONE = 0;
  localparam int unsigned EV_IO = 1;
  localparam int unsigned EV_GSR = 2;
endpackage

// File: rtl/su_sync.sv
module su_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/su_tick.sv
module su_tick #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uclk_i,
  input  logic use_uclk_i,
  output logic tick_o
);
  logic uclk_s, uclk_prev;

  su_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_usync (
    .clk(clk), .rst_n(rst_n), .d_i(uclk_i), .q_o(uclk_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uclk_prev <= 1'b0;
    else        uclk_prev <= uclk_s;
  end

  assign tick_o = use_uclk_i ? (uclk_s & ~uclk_prev) : 1'b1;

  // R8: in user-clock mode two ticks never come back to back
  p_tick_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (use_uclk_i && tick_o) |=> !(use_uclk_i && tick_o));
endmodule

// File: rtl/su_event.sv
module su_event #(
  parameter int unsigned PH_W = 2,
  parameter int unsigned ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run_i,
  input  logic [ST_W-1:0] stage_i,
  input  logic [PH_W-1:0] sel_i,
  output logic            active_o
);
  assign active_o = run_i && (stage_i > ST_W'(sel_i));

  // R7: a fired event stays fired until start-up is left
  p_event_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && active_o) |=> (active_o || !run_i));
endmodule

// File: rtl/cfg_startup.sv
module cfg_startup
  import cfg_startup_pkg::*;
#(
  parameter int unsigned NUM_PH = 4,
  parameter int unsigned MODE_W = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PH_W = $clog2(NUM_PH),
  localparam int unsigned ST_W = $clog2(NUM_PH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_n_i,
  input  logic              cfg_done_i,
  input  logic              done_sense_i,
  input  logic              uclk_i,
  input  logic [MODE_W-1:0] mode_sel_i,
  input  logic [PH_W-1:0]   done_sel_i,
  input  logic [PH_W-1:0]   io_sel_i,
  input  logic [PH_W-1:0]   gsr_sel_i,
  input  logic              use_uclk_i,
  input  logic              sync_done_i,
  input  logic              partial_i,
  input  logic              no_gsr_i,
  input  logic              no_tri_i,
  output logic              done_oe_o,
  output logic              io_en_o,
  output logic              gsr_o,
  output logic              mem_clear_o,
  output logic              load_start_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              finished_o
);
  su_state_t        state;
  logic [ST_W-1:0]  stage;
  logic [PH_W-1:0]  sel_q [NUM_EVENTS];
  logic [MODE_W-1:0] mode_q;
  logic use_uclk_q, sync_q;
  logic next_partial, next_nogsr, next_notri;
  logic cur_nogsr, cur_notri;
  logic prog_s, done_s, tick, stall, run;
  logic [NUM_EVENTS-1:0] fired;

  su_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_psync (
    .clk(clk), .rst_n(rst_n),
    .d_i({prog_n_i, done_sense_i}), .q_o({prog_s, done_s})
  );

  su_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_n), .uclk_i(uclk_i),
    .use_uclk_i(use_uclk_q), .tick_o(tick)
  );

  assign run = (state == ST_RUN) || (state == ST_FIN);

  for (genvar ev = 0; ev < NUM_EVENTS; ev++) begin : g_event
    su_event #(.PH_W(PH_W), .ST_W(ST_W)) u_event (
      .clk(clk), .rst_n(rst_n), .run_i(run), .stage_i(stage),
      .sel_i(sel_q[ev]), .active_o(fired[ev])
    );
  end

  assign stall = sync_q && fired[EV_DONE] && !done_s && (state == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_CLEAR;
      stage        <= '0;
      mode_q       <= '0;
      use_uclk_q   <= 1'b0;
      sync_q       <= 1'b0;
      next_partial <= 1'b0;
      next_nogsr   <= 1'b0;
      next_notri   <= 1'b0;
      cur_nogsr    <= 1'b0;
      cur_notri    <= 1'b0;
      for (int i = 0; i < NUM_EVENTS; i++) sel_q[i] <= '0;
    end else if (!prog_s) begin
      state     <= ST_CLEAR;
      stage     <= '0;
      cur_nogsr <= next_nogsr;
      cur_notri <= next_notri;
    end else begin
      case (state)
        ST_CLEAR: begin
          mode_q <= mode_sel_i;
          state  <= ST_SAMPLE;
        end
        ST_SAMPLE: state <= ST_LOAD;
        ST_LOAD: begin
          if (cfg_done_i) begin
            state            <= ST_RUN;
            stage            <= '0;
            sel_q[EV_DONE]   <= done_sel_i;
            sel_q[EV_IO]     <= io_sel_i;
            sel_q[EV_GSR]    <= gsr_sel_i;
            use_uclk_q       <= use_uclk_i;
            sync_q           <= sync_done_i;
            next_partial     <= partial_i;
            next_nogsr       <= no_gsr_i;
            next_notri       <= no_tri_i;
          end
        end
        ST_RUN: begin
          if (tick && !stall) begin
            stage <= stage + 1'b1;
            if (stage == ST_W'(NUM_PH - 1)) state <= ST_FIN;
          end
        end
        default: state <= ST_FIN;
      endcase
    end
  end

  assign done_oe_o    = ~fired[EV_DONE];
  assign io_en_o      = cur_notri | fired[EV_IO];
  assign gsr_o        = ~cur_nogsr & ~fired[EV_GSR];
  assign mem_clear_o  = (state == ST_CLEAR) && !next_partial;
  assign load_start_o = (state == ST_SAMPLE);
  assign mode_o       = mode_q;
  assign finished_o   = (state == ST_FIN);

  // R1: a synchronised request wins over every state
  p_prog_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_s |=> (state == ST_CLEAR && !finished_o));
  // R2: load start is a single-cycle pulse
  p_load_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_start_o |=> !load_start_o);
  // R6: finished implies DONE is not driven
  p_done_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finished_o |-> !done_oe_o);
  // R9: the handshake stall freezes the phase counter
  p_sync_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && prog_s) |=> $stable(stage));
  // R4: the phase counter advances by at most one per cycle
  p_stage_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && prog_s) |=>
      (stage == $past(stage) || stage == $past(stage) + 1'b1));
endmodule

// File: tb/tb_cfg_startup.sv
module tb_cfg_startup;
  logic clk = 1'b0, rst_n = 1'b0, prog_n = 1'b1, cfg_done = 1'b0;
  logic uclk = 1'b0, use_uclk = 1'b0, sync_done = 1'b0, ext_hold = 1'b0;
  logic partial = 1'b0, no_gsr = 1'b0, no_tri = 1'b0;
  logic [2:0] mode_sel = '0;
  logic [1:0] dsel = '0, isel = '0, gsel = '0;
  logic done_oe, io_en, gsr, mem_clear, load_start, finished, done_sense;
  logic [2:0] mode;
  logic clear_seen;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  always #50 uclk = ~uclk;
  assign done_sense = ~done_oe & ~ext_hold;

  cfg_startup dut (
    .clk(clk), .rst_n(rst_n), .prog_n_i(prog_n), .cfg_done_i(cfg_done),
    .done_sense_i(done_sense), .uclk_i(uclk), .mode_sel_i(mode_sel),
    .done_sel_i(dsel), .io_sel_i(isel), .gsr_sel_i(gsel),
    .use_uclk_i(use_uclk), .sync_done_i(sync_done), .partial_i(partial),
    .no_gsr_i(no_gsr), .no_tri_i(no_tri), .done_oe_o(done_oe),
    .io_en_o(io_en), .gsr_o(gsr), .mem_clear_o(mem_clear),
    .load_start_o(load_start), .mode_o(mode), .finished_o(finished)
  );

  always @(negedge clk) if (mem_clear) clear_seen = 1'b1;

  // {done phase, io phase, gsr phase}
  localparam logic [5:0] VEC [6] = '{
    6'b00_01_10, 6'b11_10_01, 6'b00_00_00,
    6'b11_11_11, 6'b01_01_11, 6'b10_00_10
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic reprog(input logic [2:0] m);
    int n;
    @(negedge clk);
    mode_sel = m;
    prog_n = 1'b0;
    repeat (3) @(negedge clk);
    prog_n = 1'b1;
    n = 0;
    while (!load_start && n < 20) begin @(negedge clk); n++; end
    chk("R2 load_start pulse", load_start, 1);
    chk("R2 mode sampled", mode, m);
    mode_sel = ~m;
    @(negedge clk);
    chk("R2 load_start one cycle", load_start, 0);
  endtask

  task automatic start_load(input logic [1:0] d, i, g, input logic uu, sy, pa, ng, nt);
    dsel = d; isel = i; gsel = g; use_uclk = uu; sync_done = sy;
    partial = pa; no_gsr = ng; no_tri = nt; cfg_done = 1'b1;
    @(negedge clk);
    cfg_done = 1'b0;
    dsel = ~d; isel = ~i; gsel = ~g; use_uclk = ~uu; sync_done = ~sy;
  endtask

  task automatic wait_fin(input int bound);
    int n = 0;
    while (!finished && n < bound) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done_oe", done_oe, 1);
    chk("R1 reset io_en", io_en, 0);
    chk("R1 reset gsr", gsr, 1);
    chk("R1 reset finished", finished, 0);
    chk("R3 reset mem_clear", mem_clear, 1);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      logic [1:0] d, i, g;
      {d, i, g} = VEC[v];
      reprog(3'(v + 1));
      start_load(d, i, g, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      for (int k = 0; k <= 4; k++) begin
        if (k > 0) @(negedge clk);
        chk($sformatf("R4 R11 done_oe v%0d k%0d", v, k), done_oe, !(k > d));
        chk($sformatf("R4 R5 io_en v%0d k%0d", v, k), io_en, (k > i));
        chk($sformatf("R4 R5 gsr v%0d k%0d", v, k), gsr, !(k > g));
        chk($sformatf("R7 finished v%0d k%0d", v, k), finished, (k == 4));
      end
      cfg_done = 1'b1;
      repeat (3) @(negedge clk);
      cfg_done = 1'b0;
      chk("R7 hold after finish", {finished, done_oe, io_en, gsr}, 4'b1010);
      chk("R6 released when finished", done_oe, 0);
    end

    // handshake stall
    reprog(3'd2);
    ext_hold = 1'b1;
    start_load(2'd0, 2'd1, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    repeat (8) @(negedge clk);
    chk("R9 stall done released", done_oe, 0);
    chk("R9 stall io held", io_en, 0);
    ext_hold = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 io still off before resume", io_en, 0);
    @(negedge clk);
    chk("R9 io on at resume", io_en, 1);
    chk("R9 gsr still on", gsr, 1);
    @(negedge clk);
    chk("R9 gsr off next", gsr, 0);
    @(negedge clk);
    chk("R9 finished", finished, 1);

    // user-clock timebase
    reprog(3'd3);
    start_load(2'd0, 2'd1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (25) @(negedge clk);
    chk("R8 not finished early", finished, 0);
    wait_fin(40);
    chk("R8 finished on user clock", finished, 1);

    // partial reload kept, then suppression options
    reprog(3'd4);
    start_load(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    wait_fin(10);
    clear_seen = 1'b0;
    reprog(3'd5);
    chk("R3 no clear after partial", clear_seen, 0);
    start_load(2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    wait_fin(10);
    clear_seen = 1'b0;
    reprog(3'd6);
    chk("R3 clear when not partial", clear_seen, 1);
    chk("R10 gsr suppressed", gsr, 0);
    chk("R10 io kept enabled", io_en, 1);
    chk("R1 done driven in load", done_oe, 1);
    start_load(2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wait_fin(10);
    reprog(3'd7);
    chk("R10 gsr back on", gsr, 1);
    chk("R10 io back off", io_en, 0);

    // reprogram in the middle of start-up
    start_load(2'd0, 2'd1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    prog_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 abort done_oe", done_oe, 1);
    chk("R1 abort io_en", io_en, 0);
    chk("R1 abort gsr", gsr, 1);
    chk("R1 abort finished", finished, 0);
    prog_n = 1'b1;
    repeat (5) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog R7: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule